// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes four SDRAM arrays from reset to a state where normal accesses may start. After a start pulse in its idle state it walks a fixed command sequence. First it sends an all-banks precharge to each array in turn, 0 to 3. Every array is precharged, whether or not memory is fitted there. Next it loads each array's mode register, again 0 to 3. The mode value travels on the SDRAM address pins and no data is involved. Last, it runs a refresh timer at a short interval until a set number of refresh cycles (eight by default) have gone out to all arrays together. It then switches the timer to the normal interval and declares the memory ready.

Two things gate normal accesses: a tally of precharge commands, which must reach the array count, and the end of the fast-refresh phase. `access_inhibit` stays high until both are met. In the ready state the block issues no more commands. It only pulses `rfsh_req` once per normal interval, for whatever logic owns the command bus after start-up. Each array select is active-low, and outside a command cycle every select is high, so no array is enabled.

The states are IDLE, PRECHARGE, PRE_WAIT, MODE, MODE_WAIT, REFRESH and READY. The transitions are:
- IDLE to PRECHARGE when start is seen.
- PRECHARGE to PRE_WAIT on the following cycle.
- PRE_WAIT to PRECHARGE for the next array, or to MODE after array 3, once the precharge gap has elapsed.
- MODE to MODE_WAIT on the following cycle.
- MODE_WAIT to MODE for the next array, or to REFRESH after array 3, once the mode gap has elapsed.
- REFRESH to READY on the last fast-refresh tick.
- Any state to IDLE on synchronous reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, on the cycle after it, and in IDLE, the command pins {ras_n,cas_n,we_n} read 111 (NOP). In those cycles `sd_cs_n` is all ones, `sd_addr` is 0, `rfsh_req` and `init_done` are 0, and `access_inhibit` is 1.
- R2: A high `start` sampled in IDLE puts the precharge to array 0 on the pins in the next cycle. `start` has no effect in any other state.
- R3: A precharge shows command 010 with only address bit 10 set. It drives exactly one select low, for array 0, 1, 2 and then 3, and all four arrays are always precharged.
- R4: Successive precharges are exactly `T_RP` cycles apart, with NOP cycles between them.
- R5: A mode load shows command 000 with `sd_addr` = 0x22: CAS latency 2 in bits [6:4], sequential burst (0) in bit 3, and burst code 2 (length 4) in bits [2:0]. It goes to arrays 0 to 3 in order, and the first comes `T_RP` cycles after the last precharge.
- R6: Successive mode loads are exactly `T_MRD` cycles apart, with NOP cycles between them.
- R7: The fast-refresh phase begins `T_MRD` cycles after the last mode load. In that phase a refresh (command 001, all selects low, `rfsh_req` high) appears every `REF_MIN` cycles, first after `REF_MIN` cycles, `REF_BURST` times in total.
- R8: `init_done` rises and `access_inhibit` falls in the cycle after the last fast refresh. Before that, `access_inhibit` stays high throughout the sequence.
- R9: In READY the command pins stay NOP and `init_done` stays high. `rfsh_req` pulses for one cycle every `REF_NORM` cycles, first `REF_NORM` cycles after the last fast refresh.
- R10: A reset asserted in any cycle of the sequence gives the R1 outputs in the next cycle. A new start then replays the sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin initialization (used in IDLE only) |
| sd_cs_n | output | ARRAYS | Per-array select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address pins (precharge-all bit, mode value) |
| rfsh_req | output | 1 | One-cycle refresh request at the end of each interval |
| init_done | output | 1 | Sequence finished, memory ready |
| access_inhibit | output | 1 | High while normal accesses must be held off |

## Verification
The pins are compared with an arithmetic model in every cycle, so any wrong state or array index shows up on the clock edge where the pins diverge. A stuck wait counter moves the next precharge or mode command by a cycle. A wrong array index puts a select on the wrong bit at once. An off-by-one in the refresh tally moves the rise of `init_done` by a whole `REF_MIN` interval. A reset is applied at every cycle offset of the sequence, so a state that fails to return to idle is seen one cycle after the reset.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    // SDRAM command on {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_NOP  = 3'b111,
        CMD_PRE  = 3'b010,
        CMD_REF  = 3'b001,
        CMD_LMR  = 3'b000
    } sd_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECHARGE,
        ST_PRE_WAIT,
        ST_MODE,
        ST_MODE_WAIT,
        ST_REFRESH,
        ST_READY
    } seq_state_t;

    // Mode word: CAS latency [6:4], burst type [3], burst length code [2:0]
    function automatic int mode_word(input int cas, input int btype, input int blcode);
        return ((cas & 7) << 4) | ((btype & 1) << 3) | (blcode & 7);
    endfunction

endpackage

// File: rtl/sdinit_gap_cnt.sv
module sdinit_gap_cnt #(
    parameter int MAX_GAP = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic [$clog2(MAX_GAP+1)-1:0] limit,
    output logic                       hit
);
    localparam int W = $clog2(MAX_GAP + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + W'(1);
    end

    assign hit = run && (cnt == limit);
endmodule

// File: rtl/sdinit_rfsh_tmr.sv
module sdinit_rfsh_tmr #(
    parameter int REF_MIN  = 16,
    parameter int REF_NORM = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic use_norm,
    output logic tick
);
    localparam int TOP = (REF_NORM > REF_MIN) ? REF_NORM : REF_MIN;
    localparam int W   = $clog2(TOP + 1);

    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last = use_norm ? W'(REF_NORM - 1) : W'(REF_MIN - 1);
    assign tick = en && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/sdinit_pre_tally.sv
module sdinit_pre_tally #(
    parameter int ARRAYS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pre_fire,
    output logic all_done
);
    localparam int W = $clog2(ARRAYS + 1);

    logic [W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)                                  seen <= '0;
        else if (pre_fire && seen != W'(ARRAYS))  seen <= seen + W'(1);
    end

    assign all_done = (seen == W'(ARRAYS));
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int ARRAYS    = 4,
    parameter int ADDR_W    = 13,
    parameter int PALL_BIT  = 10,
    parameter int T_RP      = 2,
    parameter int T_MRD     = 2,
    parameter int REF_MIN   = 16,
    parameter int REF_NORM  = 512,
    parameter int REF_BURST = 8,
    parameter int CAS_LAT   = 2,
    parameter int BURST_TYP = 0,
    parameter int BURST_CODE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [ARRAYS-1:0] sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              rfsh_req,
    output logic              init_done,
    output logic              access_inhibit
);
    localparam int IDX_W     = (ARRAYS > 1) ? $clog2(ARRAYS) : 1;
    localparam int MAX_GAP   = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int GAP_W     = $clog2(MAX_GAP + 1);
    localparam int RC_W      = $clog2(REF_BURST + 1);
    localparam int MODE_WORD = mode_word(CAS_LAT, BURST_TYP, BURST_CODE);

    seq_state_t       state, state_nxt;
    logic [IDX_W-1:0] arr, arr_nxt;
    logic [RC_W-1:0]  rcnt, rcnt_nxt;
    sd_cmd_t          cmd;
    logic             gap_run, gap_hit, tick, all_pre;
    logic [GAP_W-1:0] gap_lim;
    logic             last_arr;

    assign last_arr = (arr == IDX_W'(ARRAYS - 1));
    assign gap_run  = (state == ST_PRE_WAIT) || (state == ST_MODE_WAIT);
    assign gap_lim  = (state == ST_PRE_WAIT) ? GAP_W'(T_RP - 2) : GAP_W'(T_MRD - 2);

    sdinit_gap_cnt #(.MAX_GAP(MAX_GAP)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .run   (gap_run),
        .limit (gap_lim),
        .hit   (gap_hit)
    );

    sdinit_rfsh_tmr #(.REF_MIN(REF_MIN), .REF_NORM(REF_NORM)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .en       ((state == ST_REFRESH) || (state == ST_READY)),
        .use_norm (state == ST_READY),
        .tick     (tick)
    );

    sdinit_pre_tally #(.ARRAYS(ARRAYS)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .pre_fire (cmd == CMD_PRE),
        .all_done (all_pre)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            arr   <= '0;
            rcnt  <= '0;
        end else begin
            state <= state_nxt;
            arr   <= arr_nxt;
            rcnt  <= rcnt_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        arr_nxt   = arr;
        rcnt_nxt  = rcnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_PRECHARGE;
                    arr_nxt   = '0;
                end
            end
            ST_PRECHARGE: state_nxt = ST_PRE_WAIT;
            ST_PRE_WAIT: begin
                if (gap_hit) begin
                    if (last_arr) begin
                        state_nxt = ST_MODE;
                        arr_nxt   = '0;
                    end else begin
                        state_nxt = ST_PRECHARGE;
                        arr_nxt   = arr + IDX_W'(1);
                    end
                end
            end
            ST_MODE: state_nxt = ST_MODE_WAIT;
            ST_MODE_WAIT: begin
                if (gap_hit) begin
                    if (last_arr) begin
                        state_nxt = ST_REFRESH;
                        rcnt_nxt  = '0;
                    end else begin
                        state_nxt = ST_MODE;
                        arr_nxt   = arr + IDX_W'(1);
                    end
                end
            end
            ST_REFRESH: begin
                if (tick) begin
                    rcnt_nxt = rcnt + RC_W'(1);
                    if (rcnt == RC_W'(REF_BURST - 1)) state_nxt = ST_READY;
                end
            end
            ST_READY: ;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_cs_n   = '1;
        sd_addr   = '0;
        rfsh_req  = 1'b0;
        init_done = 1'b0;
        unique case (state)
            ST_PRECHARGE: begin
                cmd               = CMD_PRE;
                sd_cs_n           = ~(ARRAYS'(1) << arr);
                sd_addr[PALL_BIT] = 1'b1;
            end
            ST_MODE: begin
                cmd     = CMD_LMR;
                sd_cs_n = ~(ARRAYS'(1) << arr);
                sd_addr = ADDR_W'(MODE_WORD);
            end
            ST_REFRESH: begin
                if (tick) begin
                    cmd      = CMD_REF;
                    sd_cs_n  = '0;
                    rfsh_req = 1'b1;
                end
            end
            ST_READY: begin
                init_done = 1'b1;
                rfsh_req  = tick;
            end
            ST_IDLE, ST_PRE_WAIT, ST_MODE_WAIT: ;
            default: ;
        endcase
    end

    assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign access_inhibit = ~(all_pre & init_done);

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int ARRAYS     = 4,
    parameter int ADDR_W     = 13,
    parameter int PALL_BIT   = 10,
    parameter int CAS_LAT    = 2,
    parameter int BURST_TYP  = 0,
    parameter int BURST_CODE = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ARRAYS-1:0] sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              rfsh_req,
    input logic              init_done,
    input logic              access_inhibit
);
    logic [2:0] c;
    logic [6:0] exp_mode;
    assign c = {sd_ras_n, sd_cas_n, sd_we_n};
    assign exp_mode = {3'(CAS_LAT), 1'(BURST_TYP), 3'(BURST_CODE)};

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (c == 3'b111 && sd_cs_n == '1 && !init_done && access_inhibit));

    p_pre_one_array_r3: assert property (@(posedge clk) disable iff (rst)
        (c == 3'b010) |-> ($countones(~sd_cs_n) == 1 && sd_addr == (ADDR_W'(1) << PALL_BIT)));

    p_pre_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (c == 3'b010) |=> (c == 3'b111));

    p_mode_value_r5: assert property (@(posedge clk) disable iff (rst)
        (c == 3'b000) |-> ($countones(~sd_cs_n) == 1 && sd_addr == ADDR_W'(exp_mode)));

    p_ref_all_arrays_r7: assert property (@(posedge clk) disable iff (rst)
        (c == 3'b001) |-> (sd_cs_n == '0 && rfsh_req && !init_done));

    p_gate_matches_done_r8: assert property (@(posedge clk) disable iff (rst)
        (init_done == !access_inhibit));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (c == 3'b111 && sd_cs_n == '1));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .ARRAYS(ARRAYS), .ADDR_W(ADDR_W), .PALL_BIT(PALL_BIT),
    .CAS_LAT(CAS_LAT), .BURST_TYP(BURST_TYP), .BURST_CODE(BURST_CODE)
) u_chk (
    .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .rfsh_req(rfsh_req), .init_done(init_done), .access_inhibit(access_inhibit)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;
    localparam int TRP  = 2;
    localparam int TMRD = 3;
    localparam int RMIN = 5;
    localparam int RNRM = 11;
    localparam int RB   = 8;
    localparam int B    = 4 * TRP + 4 * TMRD;
    localparam int RDY  = B + RB * RMIN;
    localparam int BIG  = 1000000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  sd_cs_n;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic        rfsh_req, init_done, access_inhibit;

    int cyc = 0;
    int s_tag = BIG;
    int run_end = BIG;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    sdram_init_seq #(
        .T_RP(TRP), .T_MRD(TMRD), .REF_MIN(RMIN), .REF_NORM(RNRM), .REF_BURST(RB)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .rfsh_req(rfsh_req), .init_done(init_done),
        .access_inhibit(access_inhibit)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, cyc, act, exp);
        end
    endtask

    // Per-cycle model of the pins
    always @(negedge clk) begin
        if (cyc >= 1 && !finished) begin
            logic [2:0]  ec;
            logic [3:0]  ecs;
            logic [12:0] ea;
            logic        edone, einh, ereq;
            string       tg;
            int          rel;
            ec = 3'b111; ecs = 4'hF; ea = '0; edone = 0; einh = 1; ereq = 0;
            rel = cyc - s_tag;
            if (cyc >= run_end)  tg = "R10";
            else if (rel < 0)    tg = "R1";
            else if (rel < 4 * TRP) begin
                tg = "R4";
                if (rel % TRP == 0) begin
                    tg = (rel == 0) ? "R2" : "R3";
                    ec = 3'b010; ecs = ~(4'b1 << (rel / TRP)); ea = 13'h400;
                end
            end else if (rel < B) begin
                tg = "R6";
                if ((rel - 4 * TRP) % TMRD == 0) begin
                    tg = "R5";
                    ec = 3'b000; ecs = ~(4'b1 << ((rel - 4 * TRP) / TMRD)); ea = 13'h022;
                end
            end else if (rel < RDY) begin
                tg = "R7";
                if ((rel - B + 1) % RMIN == 0) begin
                    ec = 3'b001; ecs = 4'h0; ereq = 1;
                end
            end else begin
                tg = "R9";
                edone = 1; einh = 0;
                if ((rel - (RDY - 1)) % RNRM == 0) ereq = 1;
            end
            check({sd_ras_n, sd_cas_n, sd_we_n, sd_cs_n, sd_addr} == {ec, ecs, ea},
                  tg, "cmd/cs/addr",
                  32'({sd_ras_n, sd_cas_n, sd_we_n, sd_cs_n, sd_addr}), 32'({ec, ecs, ea}));
            check(rfsh_req == ereq, tg, "rfsh_req", 32'(rfsh_req), 32'(ereq));
            check({init_done, access_inhibit} == {edone, einh},
                  (tg == "R1" || tg == "R10") ? tg : "R8", "done/inhibit",
                  32'({init_done, access_inhibit}), 32'({edone, einh}));
        end
    end

    task automatic go(input int hold);
        @(posedge clk); #1;
        start = 1'b1; s_tag = cyc + 1; run_end = BIG;
        repeat (hold) @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; run_end = cyc + 1;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(posedge clk);             // R1: idle with no start
        // R2..R9: full run with a one-cycle start
        go(1);
        repeat (RDY + 3 * RNRM + 2) @(posedge clk);
        // R2: start pulses in READY have no effect
        #1 start = 1'b1;
        repeat (3) @(posedge clk);
        #1 start = 1'b0;
        repeat (RNRM + 2) @(posedge clk);
        // R10 then R2: start held high across several states
        do_reset();
        repeat (2) @(posedge clk);
        go(TRP * 3 + 1);
        repeat (RDY + RNRM + 2) @(posedge clk);
        // R10: reset at every offset of the sequence
        for (int off = 0; off <= RDY + RNRM + 1; off++) begin
            do_reset();
            @(posedge clk);
            go(1);
            repeat (off) @(posedge clk);
        end
        do_reset();
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule